// File: doc/BRIEF.md
# Serial Flash Target Command Decoder

This block is the device side of a single-bit, mode 0 serial flash interface, reduced to its command layer and status byte. It has no storage array. The select, serial clock and data-in pins are oversampled in the system clock domain. While the device is selected it collects the opcode and any address bytes. Each state change takes effect when select is released. Status reads are answered on the data-out pin, most significant bit first.

The decoder holds three pieces of state: a write-enable latch, a busy flag and a deep power-down state. An accepted erase or program produces a one-cycle command strobe. The strobe carries a kind code and a 24-bit address to an external array model, which later returns a done pulse that clears busy. While powered down the device answers nothing except the release opcode. After a release it stays deaf for a programmable recovery time.

Top module: `sflash_cmd_decoder`

## Requirements
- R1: After reset the status byte is 0x00, powered_down is 0, cmd_valid is 0 and miso is 0.
- R2: A frame of exactly 8 bits carrying 0x06 sets the write-enable latch (status bit 1). A frame of exactly 8 bits carrying 0x04 clears it. Both take effect when select rises.
- R3: After opcode 0x05, the status byte is shifted out MSB first, starting with the falling clock edge that follows the 8th rising edge, and it repeats for every further byte. The layout is: bit 0 busy, bit 1 write-enable latch, bits 4:2 protection field (reads 0), bit 7 status-write-disable (reads 0), other bits 0. Outside a status read, miso is 0.
- R4: The erase and program opcodes produce a one-cycle cmd_valid pulse with cmd_kind and cmd_addr. The pulse appears three clocks after select rises at the pins. The opcodes are 0x20 (sector, kind 0) and 0xD8 (block, kind 1), each needing exactly 32 bits; 0xC7 (chip, kind 2, address 0), needing exactly 8 bits; and 0x02 (page program, kind 3), needing at least 32 bits in whole bytes. The address is the three bytes after the opcode, MSB first. A frame of any other length is discarded.
- R5: In the same cycle as the pulse, busy is set and the write-enable latch is cleared.
- R6: The array_done input clears busy in the next cycle. While busy, every command except a status read is ignored.
- R7: An erase or program with the write-enable latch clear produces no pulse and leaves the status unchanged.
- R8: Opcode 0xB9 enters power-down only when select rises right after the 8th bit. A frame with any other length is discarded.
- R9: In power-down only an exact 8-bit 0xAB frame is honoured, and it returns the device to normal mode. All other frames are ignored, including 0x05, which then leaves miso at 0.
- R10: After a release from power-down, any frame whose select falls within RECOVERY_CYC clocks is ignored. Frames after that time are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data in |
| array_done | input | 1 | Completion pulse from the array model |
| miso | output | 1 | Serial data out |
| cmd_valid | output | 1 | One-cycle strobe for an accepted erase or program |
| cmd_kind | output | 2 | 0 sector, 1 block, 2 chip, 3 page program |
| cmd_addr | output | 24 | Address carried with the strobe |
| status | output | 8 | Live status byte |
| powered_down | output | 1 | Power-down state |

## Verification
A corrupted write-enable latch or busy flag is visible on the status port within one clock, and at the latest on the next status-read frame. A wrong bit or byte count in the frame accounting shows up at the end of the frame in which it occurs. It either produces a strobe that the reference does not expect or loses one that it does, three clocks after select rises. A power-down or recovery flag that is stuck or leaks shows on powered_down, or as a status read that returns data when it should stay silent, during the next frame.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
    localparam int BYTE_W     = 8;
    localparam int PH_W       = 3;
    localparam int CNT_W      = 3;
    localparam int ADDR_BYTES = 3;
    localparam int ADDR_W     = ADDR_BYTES * BYTE_W;

    localparam logic [7:0] OP_WEL_SET  = 8'h06;
    localparam logic [7:0] OP_WEL_CLR  = 8'h04;
    localparam logic [7:0] OP_STAT_RD  = 8'h05;
    localparam logic [7:0] OP_ER_SECT  = 8'h20;
    localparam logic [7:0] OP_ER_BLOCK = 8'hD8;
    localparam logic [7:0] OP_ER_CHIP  = 8'hC7;
    localparam logic [7:0] OP_PROG     = 8'h02;
    localparam logic [7:0] OP_SLEEP    = 8'hB9;
    localparam logic [7:0] OP_WAKE     = 8'hAB;

    typedef enum logic [1:0] {
        KIND_SECTOR = 2'd0,
        KIND_BLOCK  = 2'd1,
        KIND_CHIP   = 2'd2,
        KIND_PAGE   = 2'd3
    } cmd_kind_e;
endpackage

// File: rtl/sfd_sync.sv
module sfd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_raw,
    input  logic sclk_raw,
    input  logic mosi_raw,
    output logic sel,
    output logic frame_start,
    output logic frame_end,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic mosi_s
);
    // bit 0: cs_n, bit 1: sclk, bit 2: mosi
    localparam logic [2:0] RST_VAL = 3'b001;

    logic [2:0] stage_q [STAGES];
    logic [1:0] prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= RST_VAL;
                end else if (g == 0) begin
                    stage_q[g] <= {mosi_raw, sclk_raw, cs_n_raw};
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 2'b01;
        else        prev_q <= stage_q[STAGES-1][1:0];
    end

    assign sel         = !stage_q[STAGES-1][0];
    assign frame_start = !stage_q[STAGES-1][0] &&  prev_q[0];
    assign frame_end   =  stage_q[STAGES-1][0] && !prev_q[0];
    assign sclk_rise   =  stage_q[STAGES-1][1] && !prev_q[1];
    assign sclk_fall   = !stage_q[STAGES-1][1] &&  prev_q[1];
    assign mosi_s      =  stage_q[STAGES-1][2];
endmodule

// File: rtl/sfd_shifter.sv
module sfd_shifter
    import sfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              frame_start,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi_s,
    input  logic              tx_en,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] rx_byte,
    output logic [CNT_W-1:0]  byte_cnt,
    output logic [PH_W-1:0]   bit_ph,
    output logic              miso
);
    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic [PH_W-1:0]   ph;
        logic [CNT_W-1:0]  cnt;
        logic              vld;
        logic              dout;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d     = shf_q;
        shf_d.vld = 1'b0;
        if (!sel) shf_d.dout = 1'b0;
        if (frame_start) begin
            shf_d.ph  = '0;
            shf_d.cnt = '0;
            shf_d.sh  = '0;
        end else if (sel && sclk_rise) begin
            shf_d.sh = {shf_q.sh[BYTE_W-2:0], mosi_s};
            shf_d.ph = shf_q.ph + 1'b1;
            if (shf_q.ph == PH_W'(BYTE_W - 1)) begin
                shf_d.vld = 1'b1;
                if (shf_q.cnt != '1) shf_d.cnt = shf_q.cnt + 1'b1;
            end
        end
        if (sel && sclk_fall) begin
            shf_d.dout = tx_en ? tx_byte[PH_W'(BYTE_W - 1) - shf_q.ph] : 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    assign byte_vld = shf_q.vld;
    assign rx_byte  = shf_q.sh;
    assign byte_cnt = shf_q.cnt;
    assign bit_ph   = shf_q.ph;
    assign miso     = shf_q.dout;
endmodule

// File: rtl/sfd_ctrl.sv
module sfd_ctrl
    import sfd_pkg::*;
#(
    parameter int RECOVERY_CYC = 300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [CNT_W-1:0]  byte_cnt,
    input  logic [PH_W-1:0]   bit_ph,
    input  logic              array_done,
    output logic              tx_en,
    output logic [BYTE_W-1:0] status,
    output logic              powered_down,
    output logic              cmd_valid,
    output cmd_kind_e         cmd_kind,
    output logic [ADDR_W-1:0] cmd_addr
);
    localparam int REC_W = (RECOVERY_CYC < 2) ? 1 : $clog2(RECOVERY_CYC + 1);

    typedef struct packed {
        logic              wel;
        logic              busy;
        logic              pd;
        logic [REC_W-1:0]  rec;
        logic              ign;
        logic              rd;
        logic [BYTE_W-1:0] op;
        logic [ADDR_W-1:0] addr;
        logic              cv;
        cmd_kind_e         kind;
        logic [ADDR_W-1:0] caddr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic exact_op, exact_addr, whole_prog;

    assign exact_op   = (byte_cnt == CNT_W'(1)) && (bit_ph == '0);
    assign exact_addr = (byte_cnt == CNT_W'(ADDR_BYTES + 1)) && (bit_ph == '0);
    assign whole_prog = (byte_cnt >= CNT_W'(ADDR_BYTES + 1)) && (bit_ph == '0);

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.cv = 1'b0;
        if (ctl_q.rec != '0) ctl_d.rec = ctl_q.rec - 1'b1;
        if (array_done && ctl_q.busy) ctl_d.busy = 1'b0;

        if (frame_start) begin
            ctl_d.ign = (ctl_q.rec != '0);
            ctl_d.rd  = 1'b0;
        end

        if (byte_vld && !ctl_q.ign) begin
            if (byte_cnt == CNT_W'(1)) begin
                ctl_d.op = rx_byte;
                ctl_d.rd = (rx_byte == OP_STAT_RD) && !ctl_q.pd;
            end else if (byte_cnt <= CNT_W'(ADDR_BYTES + 1)) begin
                ctl_d.addr = {ctl_q.addr[ADDR_W-BYTE_W-1:0], rx_byte};
            end
        end

        if (frame_end) begin
            ctl_d.rd = 1'b0;
            if (!ctl_q.ign) begin
                if (ctl_q.pd) begin
                    if (ctl_q.op == OP_WAKE && exact_op) begin
                        ctl_d.pd  = 1'b0;
                        ctl_d.rec = REC_W'(RECOVERY_CYC);
                    end
                end else if (!ctl_q.busy) begin
                    unique case (ctl_q.op)
                        OP_WEL_SET: if (exact_op) ctl_d.wel = 1'b1;
                        OP_WEL_CLR: if (exact_op) ctl_d.wel = 1'b0;
                        OP_SLEEP:   if (exact_op) ctl_d.pd  = 1'b1;
                        OP_ER_SECT, OP_ER_BLOCK: begin
                            if (exact_addr && ctl_q.wel) begin
                                ctl_d.cv    = 1'b1;
                                ctl_d.kind  = (ctl_q.op == OP_ER_SECT) ? KIND_SECTOR : KIND_BLOCK;
                                ctl_d.caddr = ctl_q.addr;
                            end
                        end
                        OP_ER_CHIP: begin
                            if (exact_op && ctl_q.wel) begin
                                ctl_d.cv    = 1'b1;
                                ctl_d.kind  = KIND_CHIP;
                                ctl_d.caddr = '0;
                            end
                        end
                        OP_PROG: begin
                            if (whole_prog && ctl_q.wel) begin
                                ctl_d.cv    = 1'b1;
                                ctl_d.kind  = KIND_PAGE;
                                ctl_d.caddr = ctl_q.addr;
                            end
                        end
                        default: ;
                    endcase
                    if (ctl_d.cv) begin
                        ctl_d.busy = 1'b1;
                        ctl_d.wel  = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // bit 7 write-disable and bits 4:2 protection are held at zero
    assign status       = {1'b0, 2'b00, 3'b000, ctl_q.wel, ctl_q.busy};
    assign tx_en        = ctl_q.rd;
    assign powered_down = ctl_q.pd;
    assign cmd_valid    = ctl_q.cv;
    assign cmd_kind     = ctl_q.kind;
    assign cmd_addr     = ctl_q.caddr;
endmodule

// File: rtl/sflash_cmd_decoder.sv
module sflash_cmd_decoder
    import sfd_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int RECOVERY_CYC = 300
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        sclk,
    input  logic        mosi,
    input  logic        array_done,
    output logic        miso,
    output logic        cmd_valid,
    output logic [1:0]  cmd_kind,
    output logic [23:0] cmd_addr,
    output logic [7:0]  status,
    output logic        powered_down
);
    logic              sel, frame_start, frame_end, sclk_rise, sclk_fall, mosi_s;
    logic              byte_vld, tx_en;
    logic [BYTE_W-1:0] rx_byte;
    logic [CNT_W-1:0]  byte_cnt;
    logic [PH_W-1:0]   bit_ph;
    cmd_kind_e         kind;

    sfd_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n_raw    (cs_n),
        .sclk_raw    (sclk),
        .mosi_raw    (mosi),
        .sel         (sel),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .sclk_rise   (sclk_rise),
        .sclk_fall   (sclk_fall),
        .mosi_s      (mosi_s)
    );

    sfd_shifter i_shifter (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel),
        .frame_start (frame_start),
        .sclk_rise   (sclk_rise),
        .sclk_fall   (sclk_fall),
        .mosi_s      (mosi_s),
        .tx_en       (tx_en),
        .tx_byte     (status),
        .byte_vld    (byte_vld),
        .rx_byte     (rx_byte),
        .byte_cnt    (byte_cnt),
        .bit_ph      (bit_ph),
        .miso        (miso)
    );

    sfd_ctrl #(.RECOVERY_CYC(RECOVERY_CYC)) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .frame_end    (frame_end),
        .byte_vld     (byte_vld),
        .rx_byte      (rx_byte),
        .byte_cnt     (byte_cnt),
        .bit_ph       (bit_ph),
        .array_done   (array_done),
        .tx_en        (tx_en),
        .status       (status),
        .powered_down (powered_down),
        .cmd_valid    (cmd_valid),
        .cmd_kind     (kind),
        .cmd_addr     (cmd_addr)
    );

    assign cmd_kind = kind;
endmodule

// File: rtl/sfd_checker.sv
module sfd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       array_done,
    input logic       miso,
    input logic       cmd_valid,
    input logic [7:0] status,
    input logic       powered_down
);
    // R4
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R7
    cmd_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(status[1]));

    // R5
    cmd_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (status[0] && !status[1]));

    // R6
    busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> $past(array_done));

    // R9
    pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        powered_down |-> (!miso && !cmd_valid));
endmodule

bind sflash_cmd_decoder sfd_checker i_sfd_checker (.*);

// File: tb/test_sflash_cmd_decoder.sv
module test_sflash_cmd_decoder;
    localparam int REC  = 40;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n, cs_n, sclk, mosi, array_done;
    logic        miso, cmd_valid, powered_down;
    logic [1:0]  cmd_kind;
    logic [23:0] cmd_addr;
    logic [7:0]  status;

    int    checks = 0, errors = 0, cyc = 0, rel_cyc = -100000;
    bit    finished = 1'b0;
    string cur_req = "R1";

    logic       exp_wel = 0, exp_busy = 0, exp_pd = 0, exp_cv = 0;
    logic [1:0] exp_kind = 0;
    logic [23:0] exp_addr = 0;

    always #5 clk = ~clk;

    sflash_cmd_decoder #(.RECOVERY_CYC(REC)) i_sflash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .array_done(array_done), .miso(miso), .cmd_valid(cmd_valid),
        .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .status(status),
        .powered_down(powered_down)
    );

    task automatic expect_eq(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", cur_req, what, act, exp, cyc);
        end
    endtask

    task automatic check_all();
        expect_eq("status", 32'(status), 32'({6'b0, exp_wel, exp_busy}));
        expect_eq("powered_down", 32'(powered_down), 32'(exp_pd));
        expect_eq("cmd_valid", 32'(cmd_valid), 32'(exp_cv));
        if (exp_cv) begin
            expect_eq("cmd_kind", 32'(cmd_kind), 32'(exp_kind));
            expect_eq("cmd_addr", 32'(cmd_addr), 32'(exp_addr));
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        check_all();
    endtask

    // reference rules applied when select is released
    task automatic model_end(input logic [47:0] data, input int nbits, input bit ign);
        logic [7:0] op;
        bit accept;
        op = data[47:40];
        accept = 0;
        if (ign || nbits < 8) return;
        if (exp_pd) begin
            if (op == 8'hAB && nbits == 8) begin
                exp_pd = 0;
                rel_cyc = cyc;
            end
            return;
        end
        if (exp_busy) return;
        case (op)
            8'h06: if (nbits == 8) exp_wel = 1;
            8'h04: if (nbits == 8) exp_wel = 0;
            8'hB9: if (nbits == 8) exp_pd = 1;
            8'h20: if (nbits == 32 && exp_wel) begin accept = 1; exp_kind = 0; exp_addr = data[39:16]; end
            8'hD8: if (nbits == 32 && exp_wel) begin accept = 1; exp_kind = 1; exp_addr = data[39:16]; end
            8'hC7: if (nbits == 8 && exp_wel)  begin accept = 1; exp_kind = 2; exp_addr = 0; end
            8'h02: if (nbits >= 32 && nbits % 8 == 0 && exp_wel) begin
                accept = 1; exp_kind = 3; exp_addr = data[39:16];
            end
            default: ;
        endcase
        if (accept) begin
            exp_cv = 1; exp_busy = 1; exp_wel = 0;
        end
    endtask

    task automatic spi_frame(input logic [47:0] data, input int nbits, input int rd_bytes);
        int total;
        bit ign;
        logic [15:0] rd, exp_rd;
        total = nbits + 8 * rd_bytes;
        ign = (cyc - rel_cyc) < REC;
        rd = 0;
        exp_rd = (data[47:40] == 8'h05 && !ign && !exp_pd) ? {2{6'b0, exp_wel, exp_busy}} : 16'h0;
        cs_n = 0;
        repeat (HALF) step();
        for (int i = 0; i < total; i++) begin
            mosi = (i < nbits) ? data[47 - i] : 1'b0;
            repeat (HALF) step();
            if (i >= nbits) rd = {rd[14:0], miso};
            sclk = 1;
            repeat (HALF) step();
            sclk = 0;
        end
        repeat (HALF) step();
        cs_n = 1;
        step();
        step();
        model_end(data, total, ign);
        step();
        exp_cv = 0;
        repeat (4) step();
        if (rd_bytes > 0) expect_eq("miso read data", 32'(rd), 32'(exp_rd));
    endtask

    task automatic pulse_done();
        array_done = 1;
        exp_busy = 0;
        step();
        array_done = 0;
        step();
    endtask

    initial begin
        rst_n = 0; cs_n = 1; sclk = 0; mosi = 0; array_done = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        cur_req = "R1";
        step();
        expect_eq("miso at reset", 32'(miso), 32'h0);
        repeat (3) step();

        cur_req = "R3";  spi_frame({8'h05, 40'h0}, 8, 2);
        cur_req = "R7";  spi_frame({8'h20, 24'h012345, 16'h0}, 32, 0);
        cur_req = "R2";  spi_frame({8'h06, 40'h0}, 8, 0);
        cur_req = "R3";  spi_frame({8'h05, 40'h0}, 8, 2);
        cur_req = "R2";  spi_frame({8'h04, 40'h0}, 8, 0);
        cur_req = "R2";  spi_frame({8'h06, 40'h0}, 8, 0);
        // R4 wrong length discarded, latch kept
        cur_req = "R4";  spi_frame({8'h20, 24'h12A5C3, 16'h0}, 24, 0);
        cur_req = "R4";  spi_frame({8'h20, 24'h12A5C3, 16'h0}, 32, 0);
        // R6 busy: write-enable ignored, status read still answers
        cur_req = "R6";  spi_frame({8'h06, 40'h0}, 8, 0);
        cur_req = "R6";  spi_frame({8'h05, 40'h0}, 8, 2);
        cur_req = "R6";  pulse_done();
        cur_req = "R5";  spi_frame({8'h06, 40'h0}, 8, 0);
        cur_req = "R5";  spi_frame({8'hD8, 24'hFF0001, 16'h0}, 32, 0);
        pulse_done();
        cur_req = "R4";  spi_frame({8'h06, 40'h0}, 8, 0);
        cur_req = "R4";  spi_frame({8'hC7, 40'hFFFFFFFFFF}, 8, 0);
        pulse_done();
        spi_frame({8'h06, 40'h0}, 8, 0);
        cur_req = "R4";  spi_frame({8'h02, 24'h000100, 16'hA55A}, 44, 0);
        cur_req = "R4";  spi_frame({8'h02, 24'h000100, 16'hA55A}, 48, 0);
        pulse_done();
        cur_req = "R8";  spi_frame({8'hB9, 40'h0}, 9, 0);
        cur_req = "R8";  spi_frame({8'hB9, 40'h0}, 16, 0);
        cur_req = "R8";  spi_frame({8'hB9, 40'h0}, 8, 0);
        cur_req = "R9";  spi_frame({8'h05, 40'h0}, 8, 2);
        cur_req = "R9";  spi_frame({8'h06, 40'h0}, 8, 0);
        cur_req = "R9";  spi_frame({8'hAB, 40'h0}, 8, 0);
        cur_req = "R10"; spi_frame({8'h06, 40'h0}, 8, 0);
        repeat (REC + 10) step();
        cur_req = "R10"; spi_frame({8'h06, 40'h0}, 8, 0);
        cur_req = "R10"; spi_frame({8'h05, 40'h0}, 8, 2);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule